// File: doc/BRIEF.md
# Byte-pair configuration register decoder

This block sits between a host byte link and the configuration bank of a logic capture front end. Bytes arrive on a valid/ready stream, one byte per accepted transfer. The block groups them into address/data pairs and uses each pair to update one of a small set of registers:

- two threshold codes, one per channel group;
- a channel mode byte that selects differential pairing;
- three device identifier bytes.

A further address is not stored at all. A write to it becomes a one-cycle strobe that carries the data byte.

Every register has a one-cycle update pulse. Downstream logic (comparator DAC loaders, pairing muxes, an identifier matcher) can act on a change without polling. A combined flag reports that all three identifier bytes are nonzero.

The stream never applies back-pressure once reset is released. `in_ready` is low while reset is asserted and high at all other times. The host may leave gaps of any length between bytes, including between an address byte and its data byte.

Top module: `cfg_pair_decoder`

## Requirements
- R1: After reset, `thr_lo` and `thr_hi` are 0x7F, `mode` is 0x40, all three identifier bytes are 0x00, `id_valid` is 0 and no update pulse or strobe is high.
- R2: In the address-expecting state, a byte with bit 7 set is taken as an address. The next accepted byte is always its data byte, whatever its value. Pairs may follow back to back. Register values and pulses change on the clock edge that accepts the data byte.
- R3: A byte with bit 7 clear that arrives in the address-expecting state is dropped. The block stays in that state, and no register, pulse or strobe changes.
- R4: Address 0x89 writes `thr_lo` (channels 1 to 4) and address 0x8A writes `thr_hi` (channels 5 to 9). A write to one leaves the other unchanged.
- R5: Address 0x88 stores the full data byte in `mode`. `pair56_diff` equals `mode` bit 4 and `pair78_diff` equals `mode` bit 3, so 0x40, 0x50, 0x48 and 0x58 give none, 5/6, 7/8 and both.
- R6: Addresses 0x8C, 0x8E and 0x8F write identifier bytes 0, 1 and 2. Bit 7 of the stored byte is always 0, and bits 6..0 equal the data byte.
- R7: `id_valid` is 1 exactly when all three identifier bytes are nonzero. Writing 0x00 to any of them clears it.
- R8: A write to address 0x8D raises `seq_strobe` for one cycle with `seq_data` equal to the data byte. No stored register changes.
- R9: A pair whose address is not one of 0x88, 0x89, 0x8A, 0x8C, 0x8D, 0x8E or 0x8F is consumed. No register, pulse or strobe changes.
- R10: A byte is taken only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is 0 during reset and 1 afterwards. Idle cycles between the address byte and the data byte do not break the pair.
- R11: Each update pulse (`upd_thr_lo`, `upd_thr_hi`, `upd_mode`, `upd_id[i]`, with bit i for identifier byte i) and `seq_strobe` lasts one cycle. At most one of them is high in any cycle, and it is high exactly when its register was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Block ready to take a byte |
| in_data | input | 8 | Host byte |
| thr_lo | output | 8 | Threshold code, channels 1 to 4 |
| thr_hi | output | 8 | Threshold code, channels 5 to 9 |
| mode | output | 8 | Channel mode byte |
| pair56_diff | output | 1 | Channels 5/6 differential |
| pair78_diff | output | 1 | Channels 7/8 differential |
| id_byte0 | output | 8 | Identifier byte 0 |
| id_byte1 | output | 8 | Identifier byte 1 |
| id_byte2 | output | 8 | Identifier byte 2 |
| id_valid | output | 1 | All identifier bytes nonzero |
| upd_thr_lo | output | 1 | `thr_lo` written this cycle |
| upd_thr_hi | output | 1 | `thr_hi` written this cycle |
| upd_mode | output | 1 | `mode` written this cycle |
| upd_id | output | 3 | Identifier byte i written this cycle |
| seq_strobe | output | 1 | Sequencing write strobe |
| seq_data | output | 8 | Data of the last sequencing write |

## Verification
Every result of a pair is due in the cycle right after the edge that accepts the data byte. This covers the register values, the mode flags, `id_valid`, the pulses and the strobe, because the data byte decodes straight into the registers.

Accepting an address byte produces nothing, and neither does a dropped byte. The bench drives each byte at a falling edge. It checks the whole output set at the next falling edge, which falls inside that single result cycle. It therefore catches both a missing pulse and a pulse that lasts too long.

Expected values come from an arithmetic model of the map. The bench applies that model to full sweeps of addresses, identifier data and misframed bytes.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int BYTE_W  = 8;
  localparam int ID_BYTES = 3;

  localparam logic [BYTE_W-1:0] ADR_MODE   = 8'h88;
  localparam logic [BYTE_W-1:0] ADR_THR_LO = 8'h89;
  localparam logic [BYTE_W-1:0] ADR_THR_HI = 8'h8A;
  localparam logic [BYTE_W-1:0] ADR_SEQ    = 8'h8D;

  localparam int MODE_BIT_P56 = 4;
  localparam int MODE_BIT_P78 = 3;

  typedef enum logic {FR_ADDR, FR_DATA} fr_state_e;

  function automatic logic [BYTE_W-1:0] id_addr(input int idx);
    case (idx)
      0:       id_addr = 8'h8C;
      1:       id_addr = 8'h8E;
      default: id_addr = 8'h8F;
    endcase
  endfunction
endpackage

// File: rtl/cfgdec_framer.sv
module cfgdec_framer
  import cfgdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              wr_fire,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  fr_state_e         state_q;
  logic [BYTE_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FR_ADDR;
      addr_q  <= '0;
    end else if (take) begin
      case (state_q)
        FR_ADDR: begin
          // only a marked byte opens a pair; unmarked bytes are discarded
          if (byte_in[BYTE_W-1]) begin
            addr_q  <= byte_in;
            state_q <= FR_DATA;
          end
        end
        default: state_q <= FR_ADDR;
      endcase
    end
  end

  assign wr_fire = take && (state_q == FR_DATA);
  assign wr_addr = addr_q;
  assign wr_data = byte_in;
endmodule

// File: rtl/cfgdec_regbank.sv
module cfgdec_regbank
  import cfgdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] THR_RST  = 8'h7F,
  parameter logic [BYTE_W-1:0] MODE_RST = 8'h40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_fire,
  input  logic [BYTE_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [BYTE_W-1:0]          thr_lo,
  output logic [BYTE_W-1:0]          thr_hi,
  output logic [BYTE_W-1:0]          mode,
  output logic [ID_BYTES*BYTE_W-1:0] id_flat,
  output logic                       id_valid,
  output logic                       upd_thr_lo,
  output logic                       upd_thr_hi,
  output logic                       upd_mode,
  output logic [ID_BYTES-1:0]        upd_id,
  output logic                       seq_strobe,
  output logic [BYTE_W-1:0]          seq_data
);
  localparam int ID_W = BYTE_W - 1;

  logic hit_lo, hit_hi, hit_mode, hit_seq;
  logic [ID_BYTES-1:0] hit_id;
  logic [ID_BYTES-1:0] id_nz;

  assign hit_lo   = wr_fire && (wr_addr == ADR_THR_LO);
  assign hit_hi   = wr_fire && (wr_addr == ADR_THR_HI);
  assign hit_mode = wr_fire && (wr_addr == ADR_MODE);
  assign hit_seq  = wr_fire && (wr_addr == ADR_SEQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_lo     <= THR_RST;
      thr_hi     <= THR_RST;
      mode       <= MODE_RST;
      seq_data   <= '0;
      upd_thr_lo <= 1'b0;
      upd_thr_hi <= 1'b0;
      upd_mode   <= 1'b0;
      seq_strobe <= 1'b0;
    end else begin
      upd_thr_lo <= hit_lo;
      upd_thr_hi <= hit_hi;
      upd_mode   <= hit_mode;
      seq_strobe <= hit_seq;
      if (hit_lo)   thr_lo   <= wr_data;
      if (hit_hi)   thr_hi   <= wr_data;
      if (hit_mode) mode     <= wr_data;
      if (hit_seq)  seq_data <= wr_data;
    end
  end

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    logic [ID_W-1:0] id_q;
    logic            upd_q;

    assign hit_id[g] = wr_fire && (wr_addr == id_addr(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        id_q  <= '0;
        upd_q <= 1'b0;
      end else begin
        upd_q <= hit_id[g];
        if (hit_id[g]) id_q <= wr_data[ID_W-1:0];
      end
    end

    // the top bit is never stored, so it reads back as zero
    assign id_flat[g*BYTE_W +: BYTE_W] = {1'b0, id_q};
    assign id_nz[g]  = |id_q;
    assign upd_id[g] = upd_q;
  end

  assign id_valid = &id_nz;
endmodule

// File: rtl/cfg_pair_decoder.sv
module cfg_pair_decoder
  import cfgdec_pkg::*;
#(
  parameter logic [7:0] THR_RST  = 8'h7F,
  parameter logic [7:0] MODE_RST = 8'h40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic [7:0] thr_lo,
  output logic [7:0] thr_hi,
  output logic [7:0] mode,
  output logic       pair56_diff,
  output logic       pair78_diff,
  output logic [7:0] id_byte0,
  output logic [7:0] id_byte1,
  output logic [7:0] id_byte2,
  output logic       id_valid,
  output logic       upd_thr_lo,
  output logic       upd_thr_hi,
  output logic       upd_mode,
  output logic [2:0] upd_id,
  output logic       seq_strobe,
  output logic [7:0] seq_data
);
  logic                       ready_q;
  logic                       take;
  logic                       wr_fire;
  logic [BYTE_W-1:0]          wr_addr;
  logic [BYTE_W-1:0]          wr_data;
  logic [ID_BYTES*BYTE_W-1:0] id_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q && rst_n;
  assign take     = in_valid && in_ready;

  cfgdec_framer u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .byte_in (in_data),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  cfgdec_regbank #(
    .THR_RST  (THR_RST),
    .MODE_RST (MODE_RST)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .thr_lo     (thr_lo),
    .thr_hi     (thr_hi),
    .mode       (mode),
    .id_flat    (id_flat),
    .id_valid   (id_valid),
    .upd_thr_lo (upd_thr_lo),
    .upd_thr_hi (upd_thr_hi),
    .upd_mode   (upd_mode),
    .upd_id     (upd_id),
    .seq_strobe (seq_strobe),
    .seq_data   (seq_data)
  );

  assign id_byte0    = id_flat[0*BYTE_W +: BYTE_W];
  assign id_byte1    = id_flat[1*BYTE_W +: BYTE_W];
  assign id_byte2    = id_flat[2*BYTE_W +: BYTE_W];
  assign pair56_diff = mode[MODE_BIT_P56];
  assign pair78_diff = mode[MODE_BIT_P78];
endmodule

// File: rtl/cfgdec_chk.sv
module cfgdec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic [7:0] thr_lo,
  input logic [7:0] thr_hi,
  input logic [7:0] mode,
  input logic [7:0] id_byte0,
  input logic [7:0] id_byte1,
  input logic [7:0] id_byte2,
  input logic       id_valid,
  input logic       upd_thr_lo,
  input logic       upd_thr_hi,
  input logic       upd_mode,
  input logic [2:0] upd_id,
  input logic       seq_strobe,
  input logic [7:0] seq_data
);
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_thr_lo, upd_thr_hi, upd_mode, upd_id, seq_strobe})); // R11

  AST_THR_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_thr_lo |-> $stable(thr_lo)); // R4

  AST_THR_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_thr_hi |-> $stable(thr_hi)); // R4

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_mode |-> $stable(mode)); // R5

  AST_ID_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_byte0[7] || id_byte1[7] || id_byte2[7])); // R6

  AST_IDV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_id == 3'b000) |-> $stable(id_valid)); // R7

  AST_SEQ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    seq_strobe |-> (seq_data == $past(in_data) && $past(in_valid && in_ready))); // R8

  AST_UPD_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_thr_lo || upd_thr_hi || upd_mode || (upd_id != 3'b000))
      |-> $past(in_valid && in_ready)); // R10

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_mode |=> !upd_mode); // R11
endmodule

bind cfg_pair_decoder cfgdec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .thr_lo     (thr_lo),
  .thr_hi     (thr_hi),
  .mode       (mode),
  .id_byte0   (id_byte0),
  .id_byte1   (id_byte1),
  .id_byte2   (id_byte2),
  .id_valid   (id_valid),
  .upd_thr_lo (upd_thr_lo),
  .upd_thr_hi (upd_thr_hi),
  .upd_mode   (upd_mode),
  .upd_id     (upd_id),
  .seq_strobe (seq_strobe),
  .seq_data   (seq_data)
);

// File: tb/cfg_pair_decoder_tb.sv
`timescale 1ns/1ps
module cfg_pair_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [7:0] thr_lo, thr_hi, mode, id_byte0, id_byte1, id_byte2, seq_data;
  logic       pair56_diff, pair78_diff, id_valid;
  logic       upd_thr_lo, upd_thr_hi, upd_mode, seq_strobe;
  logic [2:0] upd_id;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] e_lo, e_hi, e_mode;
  logic [7:0] e_id [3];

  always #2.5 clk = ~clk;

  cfg_pair_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .thr_lo(thr_lo), .thr_hi(thr_hi), .mode(mode),
    .pair56_diff(pair56_diff), .pair78_diff(pair78_diff),
    .id_byte0(id_byte0), .id_byte1(id_byte1), .id_byte2(id_byte2),
    .id_valid(id_valid), .upd_thr_lo(upd_thr_lo), .upd_thr_hi(upd_thr_hi),
    .upd_mode(upd_mode), .upd_id(upd_id), .seq_strobe(seq_strobe),
    .seq_data(seq_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] pulses();
    return {seq_strobe, upd_id, upd_mode, upd_thr_hi, upd_thr_lo};
  endfunction

  // full output comparison against the bench model
  task automatic check_all(input string req, input logic [6:0] exp_p,
                           input logic [7:0] exp_seq);
    chk(req, "thr_lo", {24'd0, thr_lo}, {24'd0, e_lo});
    chk(req, "thr_hi", {24'd0, thr_hi}, {24'd0, e_hi});
    chk(req, "mode", {24'd0, mode}, {24'd0, e_mode});
    chk(req, "pair56", {31'd0, pair56_diff}, {31'd0, e_mode[4]});
    chk(req, "pair78", {31'd0, pair78_diff}, {31'd0, e_mode[3]});
    chk(req, "id0", {24'd0, id_byte0}, {24'd0, e_id[0]});
    chk(req, "id1", {24'd0, id_byte1}, {24'd0, e_id[1]});
    chk(req, "id2", {24'd0, id_byte2}, {24'd0, e_id[2]});
    chk(req, "id_valid", {31'd0, id_valid},
        {31'd0, (e_id[0] != 0) && (e_id[1] != 0) && (e_id[2] != 0)});
    chk(req, "pulses", {25'd0, pulses()}, {25'd0, exp_p});
    if (exp_p[6]) chk(req, "seq_data", {24'd0, seq_data}, {24'd0, exp_seq});
  endtask

  // model of one pair; returns expected pulse vector
  function automatic logic [6:0] model(input logic [7:0] a, input logic [7:0] d);
    logic [6:0] p = '0;
    case (a)
      8'h89: begin e_lo = d; p[0] = 1'b1; end
      8'h8A: begin e_hi = d; p[1] = 1'b1; end
      8'h88: begin e_mode = d; p[2] = 1'b1; end
      8'h8C: begin e_id[0] = d & 8'h7F; p[3] = 1'b1; end
      8'h8E: begin e_id[1] = d & 8'h7F; p[4] = 1'b1; end
      8'h8F: begin e_id[2] = d & 8'h7F; p[5] = 1'b1; end
      8'h8D: p[6] = 1'b1;
      default: p = '0;
    endcase
    return p;
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pair(input string req, input logic [7:0] a, input logic [7:0] d);
    logic [6:0] ep;
    push(a);
    check_all("R2", 7'd0, 8'd0);          // address byte alone changes nothing
    push(d);
    ep = model(a, d);
    check_all(req, ep, d);
  endtask

  initial begin
    e_lo = 8'h7F; e_hi = 8'h7F; e_mode = 8'h40;
    for (int i = 0; i < 3; i++) e_id[i] = 8'h00;

    // reset with valid held high: nothing may be taken (R1, R10)
    in_valid = 1'b1;
    in_data  = 8'h89;
    repeat (4) @(negedge clk);
    chk("R10", "in_ready in reset", {31'd0, in_ready}, 32'd0);
    check_all("R1", 7'd0, 8'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "in_ready after reset", {31'd0, in_ready}, 32'd1);
    check_all("R1", 7'd0, 8'd0);

    // every address with bit 7 set (R4 R5 R6 R8 R9)
    for (int a = 128; a < 256; a++) begin
      logic [7:0] av = a[7:0];
      pair((av inside {8'h88, 8'h89, 8'h8A, 8'h8C, 8'h8D, 8'h8E, 8'h8F}) ? "R4_R9" : "R9",
           av, av ^ 8'h5A);
    end

    // threshold codes, independent groups (R4)
    begin
      logic [7:0] codes [5] = '{8'h2E, 8'h39, 8'h45, 8'h6C, 8'h7F};
      for (int i = 0; i < 5; i++) begin
        pair("R4", 8'h89, codes[i]);
        pair("R4", 8'h8A, codes[4 - i]);
      end
    end

    // pairing modes (R5)
    begin
      logic [7:0] modes [5] = '{8'h40, 8'h50, 8'h48, 8'h58, 8'h41};
      for (int i = 0; i < 5; i++) pair("R5", 8'h88, modes[i]);
    end

    // identifier masking and valid flag over all data values (R6 R7)
    pair("R7", 8'h8E, 8'h81);
    pair("R7", 8'h8F, 8'h33);
    for (int d = 0; d < 256; d++) pair("R6_R7", 8'h8C, d[7:0]);
    pair("R7", 8'h8C, 8'h00);
    pair("R7", 8'h8E, 8'h00);
    pair("R7", 8'h8F, 8'h00);

    // sequencing strobe values (R8)
    pair("R8", 8'h8D, 8'h01);
    pair("R8", 8'h8D, 8'h05);
    pair("R8", 8'h8D, 8'h02);
    pair("R8", 8'h8D, 8'h06);

    // misframed bytes are dropped; the next pair still lands (R3)
    for (int b = 0; b < 128; b++) begin
      push(b[7:0]);
      check_all("R3", 7'd0, 8'd0);
      pair("R3", 8'h89, b[7:0]);
    end

    // data byte with bit 7 set is still data, framing continues (R2)
    pair("R2", 8'h8A, 8'h8C);
    pair("R2", 8'h8C, 8'h15);

    // idle gap between address and data (R10)
    push(8'h89);
    in_data = 8'h8F;
    repeat (3) begin
      @(negedge clk);
      check_all("R10", 7'd0, 8'd0);
    end
    push(8'h11);
    check_all("R10", model(8'h89, 8'h11), 8'h11);

    // pulse lasts one cycle only (R11)
    @(negedge clk);
    check_all("R11", 7'd0, 8'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule